// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Change Interrupt

A memory-mapped general-purpose I/O block with one or two banks of pins, each bank up to 32 bits wide. Every pin has an output value bit and a direction bit. A direction bit of 1 releases the pin driver so the pin acts as an input. A direction bit of 0 makes the pin drive the stored output value. The host reads a bank's data word to get the synchronized pin level on input bits and the stored value on output bits.

Each bank has one pending-event bit. That bit is set whenever any pin configured as an input changes level, whether it rises or falls. A per-bank enable and a global enable gate these event bits onto one interrupt line. The host acknowledges an event by writing 1 to its pending bit.

The host side is a plain 32-bit register port with single-cycle write and read strobes. Read data is combinational while the read strobe is high and zero otherwise.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset, every direction bit equals DIR_RST1/DIR_RST2 and every output bit equals DOUT_RST1/DOUT_RST2. The defaults are all ones for direction and zero for data. Pending bits, bank enables and the global enable are zero, and irq is 0.
- R2: `chN_t` equals the direction register of bank N, where 1 means released/input. `chN_o` always equals the stored output value. Both change only on a write to the matching register, and the change is visible after the clock edge that takes the write.
- R3: The register offsets are fixed. Bank 1 data is at 0x000 and bank 1 direction at 0x004. Bank 2 data is at 0x008 and bank 2 direction at 0x00C. The global enable is at 0x11C, bit 31. The pending register is at 0x120, with bit 0 for bank 1 and bit 1 for bank 2. The bank-enable register is at 0x128, with bit 0 for bank 1 and bit 1 for bank 2. Enables read back as written.
- R4: A data-register read returns, per bit, the pin level delayed by two clock edges where the direction bit is 1, and the stored output value where it is 0. Bits at or above the bank width read as 0 in both data and direction registers.
- R5: A bank's pending bit becomes 1 on the third clock edge after any input-configured pin of that bank changes level, for a rise or a fall alike. Level changes on pins configured as outputs are ignored.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. When a new change event and a clearing write fall on the same edge, the bit stays set.
- R7: irq is 1 exactly when the global enable is 1 and at least one bank has both its pending bit and its enable bit at 1.
- R8: A read of any offset other than the seven listed in R3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| ch1_i | input | W1 | Bank 1 pin levels |
| ch1_o | output | W1 | Bank 1 output values |
| ch1_t | output | W1 | Bank 1 driver release, 1 = input |
| ch2_i | input | W2 | Bank 2 pin levels |
| ch2_o | output | W2 | Bank 2 output values |
| ch2_t | output | W2 | Bank 2 driver release, 1 = input |
| irq | output | 1 | Interrupt request |

## Verification
A wrong direction or output register shows on `chN_t`/`chN_o` at the first falling edge after the write. A wrong pending, enable or global-enable state shows on irq in that same cycle, since irq is combinational from those registers. A bad synchronizer or change detector surfaces three edges after the pin toggles, either as a pending bit that is missing or extra or as a data read with a wrong level. The same-edge set/clear case and output-pin toggles are aimed at the detector's masking and priority.

// File: rtl/gpio_dual_pkg.sv
// Package: register offsets and bus constants shared by the GPIO block,
// its checker and nothing else. Offsets are byte addresses.
package gpio_dual_pkg;
    localparam int BUS_W     = 32;
    localparam int NUM_BANKS = 2;
    localparam int OFS_DATA1 = 'h000;
    localparam int OFS_DIR1  = 'h004;
    localparam int OFS_DATA2 = 'h008;
    localparam int OFS_DIR2  = 'h00C;
    localparam int OFS_GIE   = 'h11C;
    localparam int OFS_STS   = 'h120;
    localparam int OFS_IEN   = 'h128;
    localparam int GIE_BIT   = 31;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Multi-stage synchronizer for a pin vector plus one extra delayed copy
// used for change detection. Assumes pins are asynchronous; the chain
// has no reset so it keeps sampling while reset is held.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            // Shift the pin sample one stage down the chain.
            if (g == 0) begin : g_first
                always_ff @(posedge clk) chain[g] <= d_i;
            end else begin : g_next
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
    assign prev_o = chain[STAGES];
endmodule

// File: rtl/gpio_bank.sv
// Module: gpio_bank
// One bank of pins: output-value and direction registers, input
// synchronizer, read-back value and an any-input-changed pulse.
// Assumes writes arrive as single-cycle strobes already decoded.
module gpio_bank #(
    parameter int          W        = 32,
    parameter logic [31:0] DOUT_RST = '0,
    parameter logic [31:0] DIR_RST  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wval,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_t,
    output logic [W-1:0] rd_val,
    output logic         chg
);
    logic [W-1:0] out_q, dir_q, lvl, lvl_prev;

    // Hold the host-written output values and directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= DOUT_RST[W-1:0];
            dir_q <= DIR_RST[W-1:0];
        end else begin
            if (wr_data) out_q <= wval;
            if (wr_dir)  dir_q <= wval;
        end
    end

    gpio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk    (clk),
        .d_i    (pin_i),
        .sync_o (lvl),
        .prev_o (lvl_prev)
    );

    // Per-bit read value and input-only change detect.
    always_comb begin
        rd_val = (dir_q & lvl) | (~dir_q & out_q);
        chg    = |((lvl ^ lvl_prev) & dir_q);
    end

    assign pin_o = out_q;
    assign pin_t = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: gpio_irq_ctrl
// Pending bits (write-1-to-clear, set wins), bank enables, global enable
// and the combined interrupt line. Assumes one change pulse per bank.
module gpio_irq_ctrl #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] chg,
    input  logic          wr_sts,
    input  logic          wr_ien,
    input  logic          wr_gie,
    input  logic [NB-1:0] wbits,
    input  logic          wgie,
    output logic [NB-1:0] sts,
    output logic [NB-1:0] ien,
    output logic          gie,
    output logic          irq
);
    // Update pending, enable and global-enable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            ien <= '0;
            gie <= 1'b0;
        end else begin
            sts <= (wr_sts ? (sts & ~wbits) : sts) | chg;
            if (wr_ien) ien <= wbits;
            if (wr_gie) gie <= wgie;
        end
    end

    // Combine gated pending bits onto the single request line.
    always_comb irq = gie & (|(sts & ien));
endmodule

// File: rtl/gpio_dual_irq.sv
// Module: gpio_dual_irq
// Top level: register decode, read mux, one or two pin banks and the
// interrupt controller. Assumes ADDR_W >= 9 and widths of 1..32.
module gpio_dual_irq
    import gpio_dual_pkg::*;
#(
    parameter int          ADDR_W    = 9,
    parameter int          W1        = 32,
    parameter int          W2        = 32,
    parameter bit          DUAL      = 1'b1,
    parameter logic [31:0] DOUT_RST1 = '0,
    parameter logic [31:0] DIR_RST1  = '1,
    parameter logic [31:0] DOUT_RST2 = '0,
    parameter logic [31:0] DIR_RST2  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [W1-1:0]     ch1_i,
    output logic [W1-1:0]     ch1_o,
    output logic [W1-1:0]     ch1_t,
    input  logic [W2-1:0]     ch2_i,
    output logic [W2-1:0]     ch2_o,
    output logic [W2-1:0]     ch2_t,
    output logic              irq
);
    logic [W1-1:0]        rd1;
    logic [W2-1:0]        rd2;
    logic [NUM_BANKS-1:0] chg, sts, ien;
    logic                 gie;
    logic                 wr_d1, wr_t1, wr_d2, wr_t2, wr_sts, wr_ien, wr_gie;

    // Decode write strobes per register.
    always_comb begin
        wr_d1  = wr_en && (addr == ADDR_W'(OFS_DATA1));
        wr_t1  = wr_en && (addr == ADDR_W'(OFS_DIR1));
        wr_d2  = wr_en && (addr == ADDR_W'(OFS_DATA2));
        wr_t2  = wr_en && (addr == ADDR_W'(OFS_DIR2));
        wr_gie = wr_en && (addr == ADDR_W'(OFS_GIE));
        wr_sts = wr_en && (addr == ADDR_W'(OFS_STS));
        wr_ien = wr_en && (addr == ADDR_W'(OFS_IEN));
    end

    gpio_bank #(.W(W1), .DOUT_RST(DOUT_RST1), .DIR_RST(DIR_RST1)) u_bank1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ch1_i),
        .wr_data (wr_d1),
        .wr_dir  (wr_t1),
        .wval    (wdata[W1-1:0]),
        .pin_o   (ch1_o),
        .pin_t   (ch1_t),
        .rd_val  (rd1),
        .chg     (chg[0])
    );

    generate
        if (DUAL) begin : g_bank2
            gpio_bank #(.W(W2), .DOUT_RST(DOUT_RST2), .DIR_RST(DIR_RST2)) u_bank2 (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (ch2_i),
                .wr_data (wr_d2),
                .wr_dir  (wr_t2),
                .wval    (wdata[W2-1:0]),
                .pin_o   (ch2_o),
                .pin_t   (ch2_t),
                .rd_val  (rd2),
                .chg     (chg[1])
            );
        end else begin : g_no_bank2
            assign ch2_o  = '0;
            assign ch2_t  = '1;
            assign rd2    = '0;
            assign chg[1] = 1'b0;
        end
    endgenerate

    gpio_irq_ctrl #(.NB(NUM_BANKS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg    (chg),
        .wr_sts (wr_sts),
        .wr_ien (wr_ien),
        .wr_gie (wr_gie),
        .wbits  (wdata[NUM_BANKS-1:0]),
        .wgie   (wdata[GIE_BIT]),
        .sts    (sts),
        .ien    (ien),
        .gie    (gie),
        .irq    (irq)
    );

    // Select read data; unmapped offsets and idle cycles give zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_DATA1): rdata = BUS_W'(rd1);
                ADDR_W'(OFS_DIR1):  rdata = BUS_W'(ch1_t);
                ADDR_W'(OFS_DATA2): rdata = DUAL ? BUS_W'(rd2) : '0;
                ADDR_W'(OFS_DIR2):  rdata = DUAL ? BUS_W'(ch2_t) : '0;
                ADDR_W'(OFS_GIE):   rdata[GIE_BIT] = gie;
                ADDR_W'(OFS_STS):   rdata[NUM_BANKS-1:0] = sts;
                ADDR_W'(OFS_IEN):   rdata[NUM_BANKS-1:0] = ien;
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_dual_irq_chk.sv
// Module: gpio_dual_irq_chk
// Property checker attached to gpio_dual_irq by bind. Observes ports and
// the pending/change signals between the banks and the controller.
module gpio_dual_irq_chk
    import gpio_dual_pkg::*;
#(
    parameter int          ADDR_W   = 9,
    parameter int          W1       = 32,
    parameter logic [31:0] DIR_RST1 = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [W1-1:0]     ch1_o,
    input logic [W1-1:0]     ch1_t,
    input logic              irq,
    input logic [1:0]        sts,
    input logic [1:0]        chg
);
    localparam logic [W1-1:0] DIR1_INIT = DIR_RST1[W1-1:0];

    AST_RESET_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch1_t == DIR1_INIT) && !irq); // R1

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch1_t)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch1_o)); // R2

    AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        chg[0] |=> sts[0]); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_STS) && wdata[0] && !chg[0]) |=> !sts[0]); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R7
endmodule

bind gpio_dual_irq gpio_dual_irq_chk #(
    .ADDR_W(ADDR_W), .W1(W1), .DIR_RST1(DIR_RST1)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .ch1_o (ch1_o),
    .ch1_t (ch1_t),
    .irq   (irq),
    .sts   (sts),
    .chg   (chg)
);

// File: tb/gpio_dual_irq_test.sv
`timescale 1ns/100ps
// Bench: behavioural per-cycle model compared every falling edge, plus
// directed register reads for each requirement.
module gpio_dual_irq_test;
    localparam int W1 = 8;
    localparam int W2 = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [W1-1:0] ch1_i = '0, ch1_o, ch1_t;
    logic [W2-1:0] ch2_i = '0, ch2_o, ch2_t;
    logic          irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    gpio_dual_irq #(
        .ADDR_W(9), .W1(W1), .W2(W2), .DUAL(1'b1),
        .DOUT_RST1(32'h0000_00A5), .DIR_RST1(32'h0000_00F0),
        .DOUT_RST2(32'h0), .DIR_RST2(32'hFFFF_FFFF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ch1_i(ch1_i), .ch1_o(ch1_o), .ch1_t(ch1_t),
        .ch2_i(ch2_i), .ch2_o(ch2_o), .ch2_t(ch2_t), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Reference model state.
    logic [W1-1:0] m_out1, m_dir1, a1, b1, c1;
    logic [W2-1:0] m_out2, m_dir2, a2, b2, c2;
    logic [1:0]    m_sts, m_ien;
    logic          m_gie;
    logic          e1, e2;

    initial begin
        {a1, b1, c1} = '0; {a2, b2, c2} = '0;
        m_out1 = '0; m_dir1 = '1; m_out2 = '0; m_dir2 = '1;
        m_sts = '0; m_ien = '0; m_gie = 1'b0;
    end

    always @(posedge clk) begin
        e1 = |((b1 ^ c1) & m_dir1);
        e2 = |((b2 ^ c2) & m_dir2);
        if (!rst_n) begin
            m_out1 = 8'hA5; m_dir1 = 8'hF0; m_out2 = '0; m_dir2 = '1;
            m_sts = '0; m_ien = '0; m_gie = 1'b0;
        end else begin
            if (wr_en && addr == 9'h120) m_sts = m_sts & ~wdata[1:0];
            m_sts = m_sts | {e2, e1};
            if (wr_en) begin
                case (addr)
                    9'h000: m_out1 = wdata[W1-1:0];
                    9'h004: m_dir1 = wdata[W1-1:0];
                    9'h008: m_out2 = wdata[W2-1:0];
                    9'h00C: m_dir2 = wdata[W2-1:0];
                    9'h11C: m_gie  = wdata[31];
                    9'h128: m_ien  = wdata[1:0];
                    default: ;
                endcase
            end
        end
        c1 = b1; b1 = a1; a1 = ch1_i;
        c2 = b2; b2 = a2; a2 = ch2_i;
    end

    function automatic logic [31:0] exp_read(logic [8:0] a);
        case (a)
            9'h000: return 32'((m_dir1 & b1) | (~m_dir1 & m_out1));
            9'h004: return 32'(m_dir1);
            9'h008: return 32'((m_dir2 & b2) | (~m_dir2 & m_out2));
            9'h00C: return 32'(m_dir2);
            9'h11C: return {m_gie, 31'b0};
            9'h120: return {30'b0, m_sts};
            9'h128: return {30'b0, m_ien};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(logic [8:0] a);
        case (a)
            9'h000, 9'h008: return "R4 data read";
            9'h004, 9'h00C, 9'h11C, 9'h128: return "R3 register read";
            9'h120: return "R5 pending read";
            default: return "R8 unmapped read";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare outputs with the model on every falling edge after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq", 32'(irq), 32'(m_gie & (|(m_sts & m_ien))));
            chk("R2 ch1_o", 32'(ch1_o), 32'(m_out1));
            chk("R2 ch1_t", 32'(ch1_t), 32'(m_dir1));
            chk("R2 ch2_o", 32'(ch2_o), 32'(m_out2));
            chk("R2 ch2_t", 32'(ch2_t), 32'(m_dir2));
            if (rd_en) chk(read_tag(addr), rdata, exp_read(addr));
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1 wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_expect(input logic [8:0] a, input logic [31:0] e, input string req);
        @(negedge clk); #1 rd_en = 1'b1; addr = a;
        @(negedge clk); chk(req, rdata, e);
        #1 rd_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 ch1_t", 32'(ch1_t), 32'hF0);
        chk("R1 ch1_o", 32'(ch1_o), 32'hA5);
        chk("R1 ch2_t", 32'(ch2_t), 32'h1F);
        chk("R1 ch2_o", 32'(ch2_o), 32'h00);
        rd_expect(9'h004, 32'hF0, "R1 dir1");
        rd_expect(9'h000, 32'h05, "R1 data1");
        rd_expect(9'h120, 32'h0, "R1 pending");
        rd_expect(9'h128, 32'h0, "R1 enable");
        rd_expect(9'h11C, 32'h0, "R1 global");

        wr(9'h128, 32'h3);
        wr(9'h11C, 32'h8000_0000);
        rd_expect(9'h128, 32'h3, "R3 enable readback");
        rd_expect(9'h11C, 32'h8000_0000, "R3 global bit31");
        @(negedge clk); #1 ch1_i = 8'h10;
        wait_n(4);
        rd_expect(9'h120, 32'h1, "R5 rise sets bank1");
        chk("R7 irq asserted", 32'(irq), 32'h1);
        rd_expect(9'h000, 32'h15, "R4 mixed read");

        wr(9'h120, 32'h0);
        rd_expect(9'h120, 32'h1, "R6 write zero keeps");
        wr(9'h120, 32'h1);
        rd_expect(9'h120, 32'h0, "R6 write one clears");
        chk("R7 irq dropped", 32'(irq), 32'h0);

        @(negedge clk); #1 ch1_i = 8'h11;
        wait_n(4);
        rd_expect(9'h120, 32'h0, "R5 output pin ignored");
        rd_expect(9'h000, 32'h15, "R4 output bit reads stored");

        @(negedge clk); #1 ch1_i = 8'h01;
        wait_n(4);
        rd_expect(9'h120, 32'h1, "R5 fall sets bank1");
        wr(9'h120, 32'h3);

        wr(9'h11C, 32'h0);
        @(negedge clk); #1 ch2_i = 5'h03;
        wait_n(4);
        rd_expect(9'h120, 32'h2, "R5 bank2 change");
        chk("R7 global off", 32'(irq), 32'h0);
        wr(9'h11C, 32'h8000_0000);
        @(negedge clk); chk("R7 global on", 32'(irq), 32'h1);
        wr(9'h128, 32'h1);
        @(negedge clk); chk("R7 bank2 masked", 32'(irq), 32'h0);
        wr(9'h120, 32'h2);

        wr(9'h004, 32'h0);
        wr(9'h000, 32'h3C);
        @(negedge clk);
        chk("R2 all outputs", 32'(ch1_t), 32'h0);
        chk("R2 driven value", 32'(ch1_o), 32'h3C);
        rd_expect(9'h000, 32'h3C, "R4 output read");
        @(negedge clk); #1 ch1_i = 8'hFF;
        wait_n(4);
        rd_expect(9'h120, 32'h0, "R5 outputs ignore pins");

        wr(9'h008, 32'hFFFF_FFFF);
        wr(9'h00C, 32'h0);
        rd_expect(9'h008, 32'h1F, "R4 upper data bits zero");
        rd_expect(9'h00C, 32'h0, "R4 dir2 written");
        wr(9'h004, 32'hFFFF_FFFF);
        rd_expect(9'h004, 32'hFF, "R4 upper dir bits zero");

        rd_expect(9'h010, 32'h0, "R8 gap offset");
        rd_expect(9'h124, 32'h0, "R8 between irq regs");
        rd_expect(9'h1FC, 32'h0, "R8 top offset");

        wr(9'h120, 32'h3);
        @(negedge clk); #1 ch1_i = 8'h00;
        @(negedge clk);
        wr(9'h120, 32'h1);
        rd_expect(9'h120, 32'h1, "R6 set beats clear");

        wait_n(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule